// File: doc/BRIEF.md
# Instruction Word Legality Decoder

This block examines one 32-bit instruction word of a small load/store processor and decides whether the word is a legal instruction. Alongside the verdict it returns the raw fields of the word and a mask that tells which of those fields the opcode actually consumes. It also returns a flag that says whether the instruction overwrites its first register operand. A loader, a program checker or a front end that must reject malformed code can use these results without decoding the word a second time.

Legality follows operand usage. A field that the opcode ignores can hold any bits. A register field is only checked for the unused code 7 when the opcode reads or writes that register. The alignment rule applies only where the low 15 bits are a memory address, and never where they are an immediate. Register 6, the program counter, is only rejected when it would be written. The decode is combinational. One register stage with a valid flag follows it, so the block can sit in a stream of words with one cycle of latency.

Opcodes are numbered 0 to 26 in this order: plus, minus, times, div, mod, neg, abs, shl, shr, band, bor, bxor, bneg, and, or, not, eq, neq, le, lt, ge, gt, move, lw, li, sw, sys.

Top module: `inst_legal_top`

## Requirements
- R1: Fields are split as opcode = word[31:27], extension = word[26:24], first register = word[23:21], second register = word[20:18], third register = word[17:15], address/immediate = word[14:0]. Each field is returned unchanged.
- R2: An opcode of 27 to 31 makes the word illegal, with an all-zero usage mask and the write flag low.
- R3: A register field equal to 7 makes the word illegal only when the usage mask marks that register field as used.
- R4: When the 15-bit field is used as an address (branches, lw, sw), a value that is not a multiple of 4 makes the word illegal. For li the field is an immediate, and any value is legal.
- R5: A word whose first register is 6 is illegal exactly when the instruction writes its first register. The six compare-and-branch opcodes, sw, and sys with extension 1, 3 or 4 do not write it.
- R6: sys with an extension above 4 is illegal. sys uses the first register only for extensions 0 to 3, and writes it only for extensions 0 and 2.
- R7: Bits in fields that the opcode does not use never change the legality verdict.
- R8: The usage mask is bit0 extension, bit1 first register, bit2 second register, bit3 third register, bit4 address, bit5 immediate. The values are:
  - three-register arithmetic and logic: 0b001110, writes;
  - neg, abs, bneg, not and move: 0b000110, writes;
  - branches: 0b010110;
  - lw: 0b010010, writes;
  - sw: 0b010010;
  - li: 0b100010, writes;
  - sys: 0b000011 for extensions 0 to 3 and 0b000001 otherwise.
  Only sys sets bit0.
- R9: The outputs show the decode of the word presented with in_valid one clock earlier. out_valid is in_valid delayed by one clock. While in_valid is low, the result outputs hold their last values.
- R10: While rst_n is low, out_valid and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | in_word carries a word to check |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Registered results are new this cycle |
| out_legal | output | 1 | Word is a legal instruction |
| out_writes_r1 | output | 1 | Instruction overwrites its first register |
| out_use | output | 6 | Operand usage mask (R8 encoding) |
| out_opcode | output | 5 | Opcode field |
| out_ext | output | 3 | Extension field |
| out_r1 | output | 3 | First register field |
| out_r2 | output | 3 | Second register field |
| out_r3 | output | 3 | Third register field |
| out_field | output | 15 | Address/immediate field |

## Verification
The bench sweeps every opcode and every extension against all first-register codes. Each of these is combined with register code 7 and with register code 0 in the other register fields, and with low-field values that are aligned and values that are not. This catches the typical faults:
- a decoder that checks register 7 in every field would reject two-register and single-register instructions carrying junk in field three;
- one that aligns every low field would reject odd immediates of li;
- one that bans register 6 everywhere would reject branches and stores through the program counter.

The sys cases at extensions 4 to 7 expose a wrong extension bound and a wrong register usage for the halt call. A final idle cycle checks that the results hold and that out_valid drops.

// File: rtl/instchk_pkg.sv
package instchk_pkg;

  localparam int WORD_W = 32;
  localparam int OPC_W  = 5;
  localparam int EXT_W  = 3;
  localparam int REG_W  = 3;
  localparam int FLD_W  = WORD_W - OPC_W - EXT_W - 3 * REG_W;
  localparam int USE_W  = 6;

  localparam int U_EXT = 0;
  localparam int U_R1  = 1;
  localparam int U_R2  = 2;
  localparam int U_R3  = 3;
  localparam int U_ADR = 4;
  localparam int U_IMM = 5;

  localparam logic [USE_W-1:0] USE_3REG = 6'b001110;
  localparam logic [USE_W-1:0] USE_2REG = 6'b000110;
  localparam logic [USE_W-1:0] USE_BRN  = 6'b010110;
  localparam logic [USE_W-1:0] USE_MEM  = 6'b010010;
  localparam logic [USE_W-1:0] USE_IMM  = 6'b100010;

  localparam logic [REG_W-1:0] REG_PC   = 3'd6;
  localparam logic [REG_W-1:0] REG_NONE = 3'd7;
  localparam logic [EXT_W-1:0] EXT_MAX  = 3'd4;
  localparam logic [EXT_W-1:0] EXT_RMAX = 3'd3;

  typedef enum logic [OPC_W-1:0] {
    OP_PLUS, OP_MINUS, OP_TIMES, OP_DIV, OP_MOD, OP_NEG, OP_ABS,
    OP_SHL, OP_SHR, OP_BAND, OP_BOR, OP_BXOR, OP_BNEG, OP_LAND,
    OP_LOR, OP_LNOT, OP_EQ, OP_NEQ, OP_LE, OP_LT, OP_GE, OP_GT,
    OP_MOVE, OP_LW, OP_LI, OP_SW, OP_SYS
  } opcode_e;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [EXT_W-1:0] ext;
    logic [REG_W-1:0] r1;
    logic [REG_W-1:0] r2;
    logic [REG_W-1:0] r3;
    logic [FLD_W-1:0] fld;
  } inst_fields_t;

  localparam int PAY_W = 2 + USE_W + WORD_W;

endpackage

// File: rtl/inst_operand_map.sv
module inst_operand_map
  import instchk_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [EXT_W-1:0] ext,
  output logic [USE_W-1:0] use_mask,
  output logic             writes_r1
);

  always_comb begin
    use_mask  = '0;
    writes_r1 = 1'b0;
    case (opc)
      OP_PLUS, OP_MINUS, OP_TIMES, OP_DIV, OP_MOD, OP_SHL, OP_SHR,
      OP_BAND, OP_BOR, OP_BXOR, OP_LAND, OP_LOR: begin
        use_mask  = USE_3REG;
        writes_r1 = 1'b1;
      end
      OP_NEG, OP_ABS, OP_BNEG, OP_LNOT, OP_MOVE: begin
        use_mask  = USE_2REG;
        writes_r1 = 1'b1;
      end
      OP_EQ, OP_NEQ, OP_LE, OP_LT, OP_GE, OP_GT: begin
        use_mask  = USE_BRN;
      end
      OP_LW: begin
        use_mask  = USE_MEM;
        writes_r1 = 1'b1;
      end
      OP_SW: begin
        use_mask  = USE_MEM;
      end
      OP_LI: begin
        use_mask  = USE_IMM;
        writes_r1 = 1'b1;
      end
      OP_SYS: begin
        use_mask[U_EXT] = 1'b1;
        use_mask[U_R1]  = (ext <= EXT_RMAX);
        writes_r1       = (ext == 3'd0) || (ext == 3'd2);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/inst_legality.sv
module inst_legality
  import instchk_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [EXT_W-1:0] ext,
  input  logic [REG_W-1:0] r1,
  input  logic [REG_W-1:0] r2,
  input  logic [REG_W-1:0] r3,
  input  logic [1:0]       fld_lo,
  input  logic [USE_W-1:0] use_mask,
  input  logic             writes_r1,
  output logic             legal
);

  logic opc_ok;
  logic reg_bad;
  logic align_bad;
  logic pc_bad;
  logic ext_bad;

  always_comb begin
    opc_ok    = (opc <= OP_SYS);
    reg_bad   = (use_mask[U_R1] && (r1 == REG_NONE)) ||
                (use_mask[U_R2] && (r2 == REG_NONE)) ||
                (use_mask[U_R3] && (r3 == REG_NONE));
    align_bad = use_mask[U_ADR] && (fld_lo != 2'b00);
    pc_bad    = writes_r1 && (r1 == REG_PC);
    ext_bad   = use_mask[U_EXT] && (ext > EXT_MAX);
    legal     = opc_ok && !reg_bad && !align_bad && !pc_bad && !ext_bad;
  end

endmodule

// File: rtl/inst_out_stage.sv
module inst_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic         vld_d;
  logic [W-1:0] data_d;

  always_comb begin
    vld_d  = in_valid;
    data_d = in_valid ? in_data : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_d;
      out_data  <= data_d;
    end
  end

endmodule

// File: rtl/inst_legal_top.sv
module inst_legal_top
  import instchk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        out_valid,
  output logic        out_legal,
  output logic        out_writes_r1,
  output logic [5:0]  out_use,
  output logic [4:0]  out_opcode,
  output logic [2:0]  out_ext,
  output logic [2:0]  out_r1,
  output logic [2:0]  out_r2,
  output logic [2:0]  out_r3,
  output logic [14:0] out_field
);

  inst_fields_t     f;
  logic [USE_W-1:0] use_mask;
  logic             writes_r1;
  logic             legal;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;
  inst_fields_t     f_q;

  assign f = inst_fields_t'(in_word);

  inst_operand_map u_map (
    .opc       (f.opc),
    .ext       (f.ext),
    .use_mask  (use_mask),
    .writes_r1 (writes_r1)
  );

  inst_legality u_legal (
    .opc       (f.opc),
    .ext       (f.ext),
    .r1        (f.r1),
    .r2        (f.r2),
    .r3        (f.r3),
    .fld_lo    (f.fld[1:0]),
    .use_mask  (use_mask),
    .writes_r1 (writes_r1),
    .legal     (legal)
  );

  assign pay_in = {legal, writes_r1, use_mask, f};

  inst_out_stage #(.W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_data  (pay_out)
  );

  assign out_legal     = pay_out[PAY_W-1];
  assign out_writes_r1 = pay_out[PAY_W-2];
  assign out_use       = pay_out[WORD_W +: USE_W];
  assign f_q           = inst_fields_t'(pay_out[WORD_W-1:0]);
  assign out_opcode    = f_q.opc;
  assign out_ext       = f_q.ext;
  assign out_r1        = f_q.r1;
  assign out_r2        = f_q.r2;
  assign out_r3        = f_q.r3;
  assign out_field     = f_q.fld;

  p_bad_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_opcode > 5'd26) |-> (!out_legal && out_use == '0 && !out_writes_r1));

  p_unused_reg7_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_r3 == 3'd7 && !out_use[U_R3] && out_opcode <= 5'd26 &&
     !(out_writes_r1 && out_r1 == REG_PC) && out_r1 != 3'd7 && out_r2 != 3'd7 &&
     !(out_use[U_ADR] && out_field[1:0] != 2'b00) &&
     !(out_opcode == 5'd26 && out_ext > 3'd4)) |-> out_legal);

  p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_use[U_ADR] && out_field[1:0] != 2'b00) |-> !out_legal);

  p_pc_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_writes_r1 && out_r1 == REG_PC) |-> !out_legal);

  p_sys_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_opcode == 5'd26 && out_ext > 3'd4) |-> !out_legal);

  p_ext_only_sys_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_use[U_EXT] |-> (out_opcode == 5'd26));

  p_one_operand_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_use[U_ADR] && out_use[U_IMM]));

  p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(pay_out)));

endmodule

// File: tb/sim_inst_legal_top.sv
`timescale 1ns/1ps
module sim_inst_legal_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        out_valid;
  logic        out_legal;
  logic        out_writes_r1;
  logic [5:0]  out_use;
  logic [4:0]  out_opcode;
  logic [2:0]  out_ext;
  logic [2:0]  out_r1;
  logic [2:0]  out_r2;
  logic [2:0]  out_r3;
  logic [14:0] out_field;

  int checks;
  int errors;

  inst_legal_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_legal(out_legal), .out_writes_r1(out_writes_r1),
    .out_use(out_use), .out_opcode(out_opcode), .out_ext(out_ext),
    .out_r1(out_r1), .out_r2(out_r2), .out_r3(out_r3), .out_field(out_field)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected {legal, writes, use[5:0]} worked out from R2..R8
  function automatic logic [7:0] expect_of(input logic [31:0] w);
    logic [4:0] op;
    logic [2:0] e;
    logic [2:0] a;
    logic [2:0] b;
    logic [2:0] c;
    logic [14:0] v;
    logic [5:0] u;
    logic wr;
    logic ok;
    op = w[31:27]; e = w[26:24]; a = w[23:21]; b = w[20:18]; c = w[17:15]; v = w[14:0];
    u = 6'd0; wr = 1'b0;
    if (op <= 4 || (op >= 7 && op <= 11) || op == 13 || op == 14) begin
      u = 6'b001110; wr = 1'b1;
    end else if (op == 5 || op == 6 || op == 12 || op == 15 || op == 22) begin
      u = 6'b000110; wr = 1'b1;
    end else if (op >= 16 && op <= 21) begin
      u = 6'b010110;
    end else if (op == 23) begin
      u = 6'b010010; wr = 1'b1;
    end else if (op == 24) begin
      u = 6'b100010; wr = 1'b1;
    end else if (op == 25) begin
      u = 6'b010010;
    end else if (op == 26) begin
      u = (e < 4) ? 6'b000011 : 6'b000001;
      wr = (e == 0) || (e == 2);
    end
    ok = (op < 27);
    if (u[1] && a == 7) ok = 1'b0;
    if (u[2] && b == 7) ok = 1'b0;
    if (u[3] && c == 7) ok = 1'b0;
    if (u[4] && (v % 4) != 0) ok = 1'b0;
    if (wr && a == 6) ok = 1'b0;
    if (op == 26 && e > 4) ok = 1'b0;
    return {ok, wr, u};
  endfunction

  task automatic check_word(input logic [31:0] w);
    logic [7:0] ex;
    ex = expect_of(w);
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R9 out_valid word=%h actual=%b expected=1", w, out_valid);
    end
    checks++;
    if (out_legal !== ex[7]) begin
      errors++;
      $display("FAIL R2/R3/R4/R5/R6/R7 legal word=%h actual=%b expected=%b", w, out_legal, ex[7]);
    end
    checks++;
    if ({out_writes_r1, out_use} !== ex[6:0]) begin
      errors++;
      $display("FAIL R5/R6/R8 writes,use word=%h actual=%b expected=%b", w,
               {out_writes_r1, out_use}, ex[6:0]);
    end
    checks++;
    if ({out_opcode, out_ext, out_r1, out_r2, out_r3, out_field} !== w) begin
      errors++;
      $display("FAIL R1 fields actual=%h expected=%h",
               {out_opcode, out_ext, out_r1, out_r2, out_r3, out_field}, w);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    check_word(w);
  endtask

  task automatic expect_legal(input logic [31:0] w, input logic lg, input string tag);
    apply(w);
    checks++;
    if (out_legal !== lg) begin
      errors++;
      $display("FAIL %s word=%h actual=%b expected=%b", tag, w, out_legal, lg);
    end
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] last;
    checks = 0; errors = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_word = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || {out_legal, out_writes_r1, out_use, out_opcode,
        out_ext, out_r1, out_r2, out_r3, out_field} !== '0) begin
      errors++;
      $display("FAIL R10 reset outputs actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // Known encodings (R1, R4, R5)
    expect_legal(32'h3871_0000, 1'b1, "R1 shl r3 r4 r2");
    expect_legal(32'hB860_00C8, 1'b1, "R4 lw aligned");
    expect_legal(32'hB860_00C9, 1'b0, "R4 lw misaligned");
    expect_legal(32'hC080_00ED, 1'b1, "R4 li odd immediate");
    expect_legal(32'hCBC0_0008, 1'b1, "R5 sw from r6");
    expect_legal(32'hB8C0_0008, 1'b0, "R5 lw into r6");
    expect_legal(32'hD4C0_0000, 1'b1, "R6 sys halt r1=6");
    expect_legal(32'hD0C0_0000, 1'b0, "R6 sys read into r6");

    // Sweep: every opcode, extension, r1; r2/r3 in {0,7}; low field varied
    for (int op = 0; op < 32; op++)
      for (int e = 0; e < 8; e++)
        for (int a = 0; a < 8; a++)
          for (int bi = 0; bi < 2; bi++)
            for (int ci = 0; ci < 2; ci++)
              for (int fi = 0; fi < 4; fi++) begin
                logic [14:0] fv;
                fv = (fi == 3) ? 15'h7FFC : 15'(fi);
                apply({op[4:0], e[2:0], a[2:0], 3'(bi * 7), 3'(ci * 7), fv});
              end

    // R9 hold while idle
    last = in_word;
    in_valid = 1'b0;
    in_word  = ~last;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 idle out_valid actual=%b expected=0", out_valid);
    end
    checks++;
    if ({out_opcode, out_ext, out_r1, out_r2, out_r3, out_field} !== last) begin
      errors++;
      $display("FAIL R9 hold actual=%h expected=%h",
               {out_opcode, out_ext, out_r1, out_r2, out_r3, out_field}, last);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule